// File: doc/BRIEF.md
# BCD Calendar Counter with Hold

This block keeps wall-clock time and a calendar in packed BCD: seconds, minutes and hours in 24-hour form, plus weekday, day of month, month and a two-digit year covering 2000 to 2099. It runs on the system clock and advances on a one-cycle slow tick input that marks each edge of a 32.768 kHz source. A prescaler divides those ticks down to one step per second.

Software reaches the block through a small word-wide register file. A write has effect on the clock edge it is presented on, and a read returns its data one cycle later. To set the time, software first raises a hold request and waits for the halted flag. It then loads the time and date words and writes zero to the hold register, which lets counting resume. A time read latches a copy of the date for a later consistent read. A separate seconds register lets software detect a roll between reads. A one-cycle pulse marks each seconds step when its enable is set.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: Registers by address: 0 control (bit0 run enable, bit1 24-hour mode flag), 1 event enable (bit0), 2 hold (bit0 request, bit1 halted, read-only), 3 time word, 4 date word, 5 time read with date latch, 6 latched date, 7 live seconds in bits 7:0. Time word: seconds 7:0, minutes 15:8, hours 23:16, bits 31:24 zero. Date word: weekday 3:0, day 15:8, month 23:16, year 31:24, bits 7:4 zero. Read data appears on rdata_o one cycle after rd_i.
- R2: After reset, control reads 0, event enable reads 0, hold reads 3, time reads 0x00000000 and date reads 0x00010100.
- R3: With the hold request set, halted rises on the clock edge that samples the HOLD_TICKS-th tick counted since the request.
- R4: Writing hold with bit0 clear drops the request and halted on that edge. Counting resumes from the loaded values, and the first step comes on the TICKS_PER_SEC-th tick after release.
- R5: Writes to the time or date word are ignored while the block is not halted.
- R6: Seconds and minutes roll over from 59 to 00 and carry. Hours roll over from 23 to 00 and carry. Every field stays valid BCD.
- R7: At midnight the day advances, and the weekday advances from 0 to 6 and wraps from 6 to 0.
- R8: The last day is 30 in months 4, 6, 9 and 11, and 31 in the other months except February. February ends on 28, or on 29 when the year value is divisible by 4 (00 included).
- R9: After the last day of month 12 the date goes to month 1 day 1, and the year advances, wrapping from 99 to 00.
- R10: No count advances while halted or while the run enable is clear; the prescaler restarts from zero then.
- R11: Reading address 5 returns the live time and latches the date; address 6 keeps that copy until the next such read, and address 7 shows the live seconds.
- R12: irq_o is high for exactly the one cycle in which a new seconds value first shows, and only when the event enable is set. TICKS_PER_SEC must be at least 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle pulse per slow-clock period |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after rd_i |
| irq_o | output | 1 | One-second event pulse |

## Verification
A register read is due one cycle after its strobe, so every bench read samples rdata_o at the falling edge after the rising edge that captured it. Seconds steps and the event pulse appear together after the edge that samples the TICKS_PER_SEC-th tick. The halted flag comes after the edge that samples the HOLD_TICKS-th tick. The bench therefore drives ticks as exact bursts of cycles and samples at the falling edge after the last ticked edge. The pulse is checked as present there and gone one cycle later. Each vector releases the hold with the prescaler at zero, so the count of seconds that elapse is exact.

// File: rtl/rtc_bcd_pkg.sv
package rtc_bcd_pkg;

    typedef enum logic [2:0] {
        RA_CTRL  = 3'd0,
        RA_EVEN  = 3'd1,
        RA_HOLD  = 3'd2,
        RA_TIME  = 3'd3,
        RA_DATE  = 3'd4,
        RA_SNAPT = 3'd5,
        RA_SNAPD = 3'd6,
        RA_SECS  = 3'd7
    } reg_addr_e;

    typedef struct packed {
        logic [7:0] pad;
        logic [7:0] hour;
        logic [7:0] min;
        logic [7:0] sec;
    } time_word_t;

    typedef struct packed {
        logic [7:0] year;
        logic [7:0] month;
        logic [7:0] day;
        logic [3:0] pad;
        logic [3:0] wday;
    } date_word_t;

    localparam time_word_t TIME_RESET = '{pad: 8'h00, hour: 8'h00, min: 8'h00, sec: 8'h00};
    localparam date_word_t DATE_RESET = '{year: 8'h00, month: 8'h01, day: 8'h01, pad: 4'h0, wday: 4'h0};

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic leap_year(input logic [7:0] y);
        logic [6:0] bin;
        bin = 7'(y[7:4]) * 7'd10 + 7'(y[3:0]);
        return bin[1:0] == 2'b00;
    endfunction

    function automatic logic [7:0] last_day(input logic [7:0] month, input logic [7:0] year);
        case (month)
            8'h02:                      return leap_year(year) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_tick_div.sv
module rtc_tick_div #(
    parameter int TICKS_PER_SEC = 32768
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic tick_i,
    input  logic run_i,
    output logic step_o
);
    localparam int CW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

    logic [CW-1:0] cnt_q;

    assign step_o = run_i && tick_i && (cnt_q == LAST);

    always_ff @(posedge clk_i) begin
        if (rst_i || !run_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/rtc_hold_ctrl.sv
module rtc_hold_ctrl #(
    parameter int HOLD_TICKS = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic tick_i,
    input  logic set_req_i,
    input  logic clr_req_i,
    output logic hold_req_o,
    output logic halted_o
);
    localparam int CW = (HOLD_TICKS > 1) ? $clog2(HOLD_TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(HOLD_TICKS - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            hold_req_o <= 1'b1;
            halted_o   <= 1'b1;
            cnt_q      <= '0;
        end else if (clr_req_i) begin
            hold_req_o <= 1'b0;
            halted_o   <= 1'b0;
            cnt_q      <= '0;
        end else begin
            if (set_req_i) hold_req_o <= 1'b1;
            if (hold_req_o && !halted_o && tick_i) begin
                if (cnt_q == LAST) begin
                    halted_o <= 1'b1;
                    cnt_q    <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/rtc_cal_core.sv
module rtc_cal_core
    import rtc_bcd_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_i,
    input  logic        step_i,
    input  logic        ld_time_i,
    input  logic        ld_date_i,
    input  logic [31:0] wdata_i,
    output time_word_t  time_o,
    output date_word_t  date_o
);
    time_word_t t_q, t_n;
    date_word_t d_q, d_n;
    logic c_min, c_hour, c_day, c_mon, c_year;
    logic unused_bits;

    assign unused_bits = ^{wdata_i[31:24], wdata_i[7:4]};

    always_comb begin
        t_n = t_q;
        d_n = d_q;
        c_min  = (t_q.sec == 8'h59);
        c_hour = c_min && (t_q.min == 8'h59);
        c_day  = c_hour && (t_q.hour == 8'h23);
        c_mon  = c_day && (d_q.day == last_day(d_q.month, d_q.year));
        c_year = c_mon && (d_q.month == 8'h12);

        t_n.sec = c_min ? 8'h00 : bcd_inc(t_q.sec);
        if (c_min)  t_n.min  = (t_q.min == 8'h59) ? 8'h00 : bcd_inc(t_q.min);
        if (c_hour) t_n.hour = (t_q.hour == 8'h23) ? 8'h00 : bcd_inc(t_q.hour);
        if (c_day) begin
            d_n.wday = (d_q.wday == 4'd6) ? 4'd0 : d_q.wday + 4'd1;
            d_n.day  = c_mon ? 8'h01 : bcd_inc(d_q.day);
        end
        if (c_mon)  d_n.month = c_year ? 8'h01 : bcd_inc(d_q.month);
        if (c_year) d_n.year  = (d_q.year == 8'h99) ? 8'h00 : bcd_inc(d_q.year);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            t_q <= TIME_RESET;
            d_q <= DATE_RESET;
        end else begin
            if (ld_time_i) begin
                t_q.pad  <= 8'h00;
                t_q.hour <= wdata_i[23:16];
                t_q.min  <= wdata_i[15:8];
                t_q.sec  <= wdata_i[7:0];
            end else if (step_i) begin
                t_q <= t_n;
            end
            if (ld_date_i) begin
                d_q.year  <= wdata_i[31:24];
                d_q.month <= wdata_i[23:16];
                d_q.day   <= wdata_i[15:8];
                d_q.pad   <= 4'h0;
                d_q.wday  <= wdata_i[3:0];
            end else if (step_i) begin
                d_q <= d_n;
            end
        end
    end

    assign time_o = t_q;
    assign date_o = d_q;
endmodule

// File: rtl/rtc_bcd_calendar.sv
module rtc_bcd_calendar
    import rtc_bcd_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768,
    parameter int HOLD_TICKS    = 2
) (
    input  logic        clk_i,
    input  logic        rst_i,
    input  logic        tick_i,
    input  logic        wr_i,
    input  logic        rd_i,
    input  logic [2:0]  addr_i,
    input  logic [31:0] wdata_i,
    output logic [31:0] rdata_o,
    output logic        irq_o
);
    reg_addr_e  addr;
    logic       run_en_q, mode24_q, ev_en_q;
    logic       hold_req, halted, running, sec_step;
    logic       set_req, clr_req, ld_time, ld_date;
    time_word_t time_word;
    date_word_t date_word, snap_date_q;
    logic [31:0] rd_val;

    assign addr    = reg_addr_e'(addr_i);
    assign set_req = wr_i && (addr == RA_HOLD) &&  wdata_i[0];
    assign clr_req = wr_i && (addr == RA_HOLD) && !wdata_i[0];
    assign ld_time = wr_i && (addr == RA_TIME) && halted;
    assign ld_date = wr_i && (addr == RA_DATE) && halted;
    assign running = run_en_q && !halted;

    rtc_hold_ctrl #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .tick_i     (tick_i),
        .set_req_i  (set_req),
        .clr_req_i  (clr_req),
        .hold_req_o (hold_req),
        .halted_o   (halted)
    );

    rtc_tick_div #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_div (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .tick_i (tick_i),
        .run_i  (running),
        .step_o (sec_step)
    );

    rtc_cal_core u_core (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .step_i    (sec_step),
        .ld_time_i (ld_time),
        .ld_date_i (ld_date),
        .wdata_i   (wdata_i),
        .time_o    (time_word),
        .date_o    (date_word)
    );

    always_comb begin
        case (addr)
            RA_CTRL:  rd_val = {30'd0, mode24_q, run_en_q};
            RA_EVEN:  rd_val = {31'd0, ev_en_q};
            RA_HOLD:  rd_val = {30'd0, halted, hold_req};
            RA_TIME:  rd_val = time_word;
            RA_DATE:  rd_val = date_word;
            RA_SNAPT: rd_val = time_word;
            RA_SNAPD: rd_val = snap_date_q;
            RA_SECS:  rd_val = {24'd0, time_word.sec};
            default:  rd_val = '0;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            run_en_q    <= 1'b0;
            mode24_q    <= 1'b0;
            ev_en_q     <= 1'b0;
            snap_date_q <= DATE_RESET;
            rdata_o     <= '0;
            irq_o       <= 1'b0;
        end else begin
            if (wr_i && addr == RA_CTRL) begin
                run_en_q <= wdata_i[0];
                mode24_q <= wdata_i[1];
            end
            if (wr_i && addr == RA_EVEN) ev_en_q <= wdata_i[0];
            if (rd_i) rdata_o <= rd_val;
            if (rd_i && addr == RA_SNAPT) snap_date_q <= date_word;
            irq_o <= sec_step && ev_en_q;
        end
    end
endmodule

// File: rtl/rtc_bcd_calendar_chk.sv
module rtc_bcd_calendar_chk (
    input logic        clk_i,
    input logic        rst_i,
    input logic        tick_i,
    input logic        wr_i,
    input logic [2:0]  addr_i,
    input logic [31:0] wdata_i,
    input logic        irq_o,
    input logic        halted,
    input logic        hold_req,
    input logic        sec_step,
    input logic [31:0] time_w,
    input logic [31:0] date_w
);
    p_halt_rise_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(halted) |-> ($past(hold_req) && $past(tick_i)));

    p_release_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_i && addr_i == 3'd2 && !wdata_i[0]) |=> (!halted && !hold_req));

    p_load_ignored_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_i && addr_i == 3'd3 && !halted && !sec_step) |=> (time_w == $past(time_w)));

    p_sec_bcd_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (time_w[3:0] <= 4'd9) && (time_w[7:4] <= 4'd5));

    p_wday_range_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        date_w[3:0] <= 4'd6);

    p_frozen_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(halted) && !$past(wr_i && (addr_i == 3'd3 || addr_i == 3'd4)))
        |-> (time_w == $past(time_w) && date_w == $past(date_w)));

    p_irq_single_r12: assert property (@(posedge clk_i) disable iff (rst_i)
        irq_o |=> !irq_o);

    p_irq_on_step_r12: assert property (@(posedge clk_i) disable iff (rst_i)
        irq_o |-> (time_w[7:0] != $past(time_w[7:0])));
endmodule

bind rtc_bcd_calendar rtc_bcd_calendar_chk u_chk (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .tick_i   (tick_i),
    .wr_i     (wr_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .irq_o    (irq_o),
    .halted   (halted),
    .hold_req (hold_req),
    .sec_step (sec_step),
    .time_w   (time_word),
    .date_w   (date_word)
);

// File: tb/rtc_bcd_calendar_test.sv
`timescale 1ns/1ps
module rtc_bcd_calendar_test;
    localparam int TPS   = 4;
    localparam int HOLDT = 2;
    localparam int NVEC  = 14;

    // {time in, date in, seconds, time expected, date expected}
    localparam logic [135:0] VEC [NVEC] = '{
        {32'h00123456, 32'h24031502, 8'd1, 32'h00123457, 32'h24031502},
        {32'h00123459, 32'h24031502, 8'd1, 32'h00123500, 32'h24031502},
        {32'h00125959, 32'h24031502, 8'd1, 32'h00130000, 32'h24031502},
        {32'h00235959, 32'h24031506, 8'd1, 32'h00000000, 32'h24031600},
        {32'h00235959, 32'h23022801, 8'd1, 32'h00000000, 32'h23030102},
        {32'h00235959, 32'h24022803, 8'd1, 32'h00000000, 32'h24022904},
        {32'h00235959, 32'h24022904, 8'd1, 32'h00000000, 32'h24030105},
        {32'h00235959, 32'h25043000, 8'd1, 32'h00000000, 32'h25050101},
        {32'h00235959, 32'h99123105, 8'd1, 32'h00000000, 32'h00010106},
        {32'h00235959, 32'h10013102, 8'd1, 32'h00000000, 32'h10020103},
        {32'h00235959, 32'h11093004, 8'd1, 32'h00000000, 32'h11100105},
        {32'h00000058, 32'h00010100, 8'd3, 32'h00000101, 32'h00010100},
        {32'h00235959, 32'h00022800, 8'd1, 32'h00000000, 32'h00022901},
        {32'h00235959, 32'h12022800, 8'd1, 32'h00000000, 32'h12022901}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wdata = 32'd0;
    logic [31:0] rdata;
    logic        irq;
    int          n_chk = 0;
    int          n_fail = 0;
    logic        done = 1'b0;
    logic [31:0] got;

    always #2.5 clk = ~clk;

    rtc_bcd_calendar #(.TICKS_PER_SEC(TPS), .HOLD_TICKS(HOLDT)) uut (
        .clk_i(clk), .rst_i(rst), .tick_i(tick), .wr_i(wr), .rd_i(rd),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        rd = 1'b1; addr = a;
        @(negedge clk);
        rd = 1'b0;
        d = rdata;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R2 reset state
        check("R2 irq", {31'd0, irq}, 32'd0);
        reg_rd(3'd0, got); check("R2 ctrl", got, 32'd0);
        reg_rd(3'd1, got); check("R2 event enable", got, 32'd0);
        reg_rd(3'd2, got); check("R2 hold", got, 32'd3);
        reg_rd(3'd3, got); check("R2 time", got, 32'h00000000);
        reg_rd(3'd4, got); check("R2 date", got, 32'h00010100);
        // R10 no counting while held after reset
        ticks(12);
        reg_rd(3'd3, got); check("R10 held after reset", got, 32'h00000000);

        reg_wr(3'd0, 32'd3);
        reg_rd(3'd0, got); check("R1 ctrl readback", got, 32'd3);

        // R6 R7 R8 R9 vector walk
        for (int i = 0; i < NVEC; i++) begin
            reg_wr(3'd3, VEC[i][135:104]);
            reg_wr(3'd4, VEC[i][103:72]);
            reg_wr(3'd2, 32'd0);
            ticks(int'(VEC[i][71:64]) * TPS);
            reg_rd(3'd3, got); check($sformatf("R6 time vector %0d", i), got, VEC[i][63:32]);
            reg_rd(3'd4, got); check($sformatf("R8 R9 date vector %0d", i), got, VEC[i][31:0]);
            reg_wr(3'd2, 32'd1);
            ticks(HOLDT);
        end

        // R3 R4 hold handshake
        reg_wr(3'd2, 32'd0);
        reg_rd(3'd2, got); check("R4 release clears hold", got, 32'd0);
        reg_wr(3'd2, 32'd1);
        reg_rd(3'd2, got); check("R3 request only", got, 32'd1);
        ticks(1);
        reg_rd(3'd2, got); check("R3 after one tick", got, 32'd1);
        ticks(1);
        reg_rd(3'd2, got); check("R3 halted", got, 32'd3);

        // R10 frozen while halted
        reg_wr(3'd3, 32'h00101010);
        ticks(20);
        reg_rd(3'd3, got); check("R10 frozen while halted", got, 32'h00101010);

        // R5 load ignored while running, R4 first step timing
        reg_wr(3'd2, 32'd0);
        reg_wr(3'd3, 32'h00050505);
        reg_rd(3'd3, got); check("R5 load ignored", got, 32'h00101010);
        ticks(TPS - 1);
        reg_rd(3'd3, got); check("R4 no step before full second", got, 32'h00101010);
        ticks(1);
        reg_rd(3'd3, got); check("R4 step on last tick", got, 32'h00101011);

        // R10 run enable clear
        reg_wr(3'd0, 32'd2);
        ticks(8);
        reg_rd(3'd3, got); check("R10 run disabled", got, 32'h00101011);
        reg_wr(3'd0, 32'd3);

        // R12 event pulse
        reg_wr(3'd1, 32'd1);
        ticks(TPS);
        check("R12 pulse present", {31'd0, irq}, 32'd1);
        @(negedge clk);
        check("R12 pulse one cycle", {31'd0, irq}, 32'd0);
        reg_rd(3'd3, got); check("R12 second stepped", got, 32'h00101012);
        reg_wr(3'd1, 32'd0);
        ticks(TPS);
        check("R12 pulse gated off", {31'd0, irq}, 32'd0);
        reg_rd(3'd3, got); check("R12 step without pulse", got, 32'h00101013);

        // R11 snapshot and seconds copy
        reg_wr(3'd2, 32'd1);
        ticks(HOLDT);
        reg_wr(3'd3, 32'h00235959);
        reg_wr(3'd4, 32'h99123105);
        reg_wr(3'd2, 32'd0);
        reg_rd(3'd5, got); check("R11 time read", got, 32'h00235959);
        ticks(TPS);
        reg_rd(3'd6, got); check("R11 latched date kept", got, 32'h99123105);
        reg_rd(3'd7, got); check("R11 live seconds", got, 32'h00000000);
        reg_rd(3'd4, got); check("R9 live date rolled", got, 32'h00010106);

        done = 1'b1;
        finish_run();
    end
endmodule